// File: doc/BRIEF.md
# Integer Execution Unit with Immediate Handling

This block is the combinational integer datapath of a load-store processor core. It takes two 32-bit register operands, a 16-bit immediate, a 5-bit shift count and a 4-bit operation code. In the same cycle it returns a 32-bit result and a signed-overflow flag. When `use_imm` is high, the second operand is the immediate rather than `src_b`. The unit widens the immediate itself, and the operation decides how: arithmetic and compare operations copy the immediate's top bit into the upper bits, while bitwise operations fill the upper bits with zeros.

Supported work:
- add and subtract, each with a trapping-style form that raises overflow and a silent form that never does;
- the four bitwise operations;
- shifts left, right logical and right arithmetic;
- signed and unsigned less-than compares;
- placing the immediate in the upper half of a word.

Any code outside the defined set gives a zero result. Multiply, divide, traps and register access belong elsewhere in the core.

Top module: `int_alu`

## Requirements
- R1: Code 0 (signed add) and code 1 (silent add) give `src_a` plus the second operand, modulo 2^32. With `use_imm`=1 the second operand is the immediate sign-extended to 32 bits, so 0x00000004 plus immediate 0xFFFF gives 0x00000003.
- R2: Code 2 (signed subtract) and code 3 (silent subtract) give `src_a` minus the second operand, modulo 2^32. The immediate is sign-extended.
- R3: `ovf` is high only for codes 0 and 2. For code 0 it is high when both addends share a sign and the sum's sign differs from it. For code 2 the same test is applied with the subtrahend negated. For every other code `ovf` is low.
- R4: Codes 4, 5, 6 and 7 give bitwise AND, OR, XOR and NOR (the complement of OR). With `use_imm`=1 the immediate is zero-extended, so 0xFFFFFFFF ANDed with immediate 0xFFFF gives 0x0000FFFF.
- R5: Codes 8, 9 and 10 shift `src_a` by `shamt` bit positions: left, right with zero fill, and right with sign fill. `src_b`, `imm` and `use_imm` have no effect on these codes.
- R6: Code 11 gives 1 when `src_a` is less than the second operand as two's-complement numbers, and 0 otherwise. The immediate is sign-extended.
- R7: Code 12 gives 1 when `src_a` is less than the second operand as unsigned numbers, and 0 otherwise. The immediate is still sign-extended before the compare.
- R8: Code 13 puts `imm` in bits 31:16 and zeros in bits 15:0. `src_a` and `src_b` have no effect.
- R9: Codes 14 and 15 give a zero result with `ovf` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | First register operand; also the value that is shifted |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Shift count |
| use_imm | input | 1 | Selects the widened immediate as the second operand |
| op_sel | input | 4 | Operation code (see requirements) |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow for codes 0 and 2 |

## Verification
The checker tests its properties only when every input is known. It assumes the core never presents X on `op_sel`, operands, immediate or shift count while reading the result. The directed stimulus drives fully defined values on every input before each sample, including those that should be ignored, so every property is active on every vector. The vectors deliberately reach the sign boundaries: 0x7FFFFFFF, 0x80000000, and an immediate of 0xFFFF. There, sign extension, signed overflow and the difference between signed and unsigned compares all show up.

// File: rtl/int_alu_pkg.sv
// Package: operation codes shared by the integer execution unit, its
// sub-blocks and its checker. Assumes a 4-bit operation select.
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDS = 4'd1,   // silent add, no overflow
        OP_SUB  = 4'd2,
        OP_SUBS = 4'd3,   // silent subtract, no overflow
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHRL = 4'd9,
        OP_SHRA = 4'd10,
        OP_LTS  = 4'd11,
        OP_LTU  = 4'd12,
        OP_UPI  = 4'd13
    } op_e;

    // Arithmetic and compare operations widen the immediate with its sign bit.
    function automatic logic wants_sign_ext(op_e op);
        return (op == OP_ADD) || (op == OP_ADDS) || (op == OP_SUB) ||
               (op == OP_SUBS) || (op == OP_LTS) || (op == OP_LTU);
    endfunction

    // Subtracts and compares both run the adder in subtract mode.
    function automatic logic wants_subtract(op_e op);
        return (op == OP_SUB) || (op == OP_SUBS) || (op == OP_LTS) || (op == OP_LTU);
    endfunction

endpackage

// File: rtl/int_alu_imm_ext.sv
// Immediate widener: extends an IMM_W-bit field to DATA_W bits, either
// copying its top bit or filling with zeros. Assumes DATA_W > IMM_W.
module int_alu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm_in,
    input  logic              sign_mode,
    output logic [DATA_W-1:0] imm_wide
);
    localparam int PAD_W = DATA_W - IMM_W;

    // Pick the fill bit for the upper part of the word.
    always_comb begin
        imm_wide = {{PAD_W{sign_mode & imm_in[IMM_W-1]}}, imm_in};
    end
endmodule

// File: rtl/int_alu_addsub.sv
// Shared adder/subtractor: one carry chain gives the sum or difference, the
// signed overflow condition and both less-than outcomes. Assumes the caller
// selects subtract mode for compares.
module int_alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              subtract,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw,
    output logic              less_s,
    output logic              less_u
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] opb_x;
    logic [DATA_W:0]   wide_sum;

    // Invert the second operand and inject a carry for subtraction.
    always_comb begin
        opb_x    = subtract ? ~opb : opb;
        wide_sum = {1'b0, opa} + {1'b0, opb_x} + {{DATA_W{1'b0}}, subtract};
        sum      = wide_sum[MSB:0];
    end

    // Derive overflow and both orderings from the carry chain outputs.
    always_comb begin
        ovf_raw = (opa[MSB] == opb_x[MSB]) && (sum[MSB] != opa[MSB]);
        less_s  = sum[MSB] ^ ovf_raw;
        less_u  = ~wide_sum[DATA_W];
    end
endmodule

// File: rtl/int_alu_bitops.sv
// Bitwise and shift unit: the four bitwise operations on two operands and the
// three shifts of the first operand by a count. Assumes SHAMT_W covers DATA_W.
module int_alu_bitops
    import int_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  op_e                opcode,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic [SHAMT_W-1:0] count,
    output logic [DATA_W-1:0]  bits_out
);
    // Select the bitwise or shift outcome for the current code.
    always_comb begin
        unique case (opcode)
            OP_AND:  bits_out = opa & opb;
            OP_OR:   bits_out = opa | opb;
            OP_XOR:  bits_out = opa ^ opb;
            OP_NOR:  bits_out = ~(opa | opb);
            OP_SHL:  bits_out = opa << count;
            OP_SHRL: bits_out = opa >> count;
            OP_SHRA: bits_out = DATA_W'($signed(opa) >>> count);
            default: bits_out = '0;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
// Integer execution unit (top): chooses the second operand, widens the
// immediate as the operation requires and steers one of the sub-block outputs
// to the result. Purely combinational; assumes the core registers around it.
module int_alu
    import int_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [IMM_W-1:0]   imm,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               use_imm,
    input  logic [3:0]         op_sel,
    output logic [DATA_W-1:0]  result,
    output logic               ovf
);
    localparam int LOW_W = DATA_W - IMM_W;

    op_e               op;
    logic              sign_mode;
    logic              sub_mode;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_ovf;
    logic              lt_signed;
    logic              lt_unsigned;
    logic [DATA_W-1:0] bits_res;

    // Decode the operation into extension and adder modes.
    always_comb begin
        op        = op_e'(op_sel);
        sign_mode = wants_sign_ext(op);
        sub_mode  = wants_subtract(op);
    end

    int_alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm_in    (imm),
        .sign_mode (sign_mode),
        .imm_wide  (imm_wide)
    );

    // Choose the register or the widened immediate as the second operand.
    always_comb begin
        opnd_b = use_imm ? imm_wide : src_b;
    end

    int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opa      (src_a),
        .opb      (opnd_b),
        .subtract (sub_mode),
        .sum      (arith_sum),
        .ovf_raw  (arith_ovf),
        .less_s   (lt_signed),
        .less_u   (lt_unsigned)
    );

    int_alu_bitops #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_bitops (
        .opcode   (op),
        .opa      (src_a),
        .opb      (opnd_b),
        .count    (shamt),
        .bits_out (bits_res)
    );

    // Steer the selected outcome to the result; unknown codes give zero.
    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDS, OP_SUB, OP_SUBS: result = arith_sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR,
            OP_SHL, OP_SHRL, OP_SHRA:         result = bits_res;
            OP_LTS:  result = {{(DATA_W-1){1'b0}}, lt_signed};
            OP_LTU:  result = {{(DATA_W-1){1'b0}}, lt_unsigned};
            OP_UPI:  result = {imm, {LOW_W{1'b0}}};
            default: result = '0;
        endcase
    end

    // Only the trapping add and subtract report overflow.
    always_comb begin
        ovf = ((op == OP_ADD) || (op == OP_SUB)) && arith_ovf;
    end
endmodule

// File: rtl/int_alu_checker.sv
// Checker for the integer execution unit: relates port values for each
// operation. Assumes fully known inputs; properties are skipped otherwise.
module int_alu_checker #(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0]  src_a,
    input logic [DATA_W-1:0]  src_b,
    input logic [IMM_W-1:0]   imm,
    input logic [SHAMT_W-1:0] shamt,
    input logic               use_imm,
    input logic [3:0]         op_sel,
    input logic [DATA_W-1:0]  result,
    input logic               ovf
);
    localparam int LOW_W = DATA_W - IMM_W;

    logic              known;
    logic [DATA_W-1:0] low_mask;

    // Gate every property on defined inputs and build the shift mask.
    always_comb begin
        known    = !$isunknown({src_a, src_b, imm, shamt, use_imm, op_sel});
        low_mask = ~({DATA_W{1'b1}} << shamt);
    end

    // Evaluate the port relations whenever the inputs are defined.
    always_comb begin
        if (known) begin
            // R3
            silent_no_ovf_chk: assert (!ovf || op_sel == 4'd0 || op_sel == 4'd2)
                else $error("overflow raised for code %0d", op_sel);
            // R9
            unused_zero_chk: assert (op_sel < 4'd14 || (result == '0 && !ovf))
                else $error("unused code %0d gave %h", op_sel, result);
            // R6
            lts_bool_chk: assert (op_sel != 4'd11 || result[DATA_W-1:1] == '0)
                else $error("signed compare not boolean: %h", result);
            // R7
            ltu_bool_chk: assert (op_sel != 4'd12 || result[DATA_W-1:1] == '0)
                else $error("unsigned compare not boolean: %h", result);
            // R8
            upper_imm_chk: assert (op_sel != 4'd13 ||
                                   result == {imm, {LOW_W{1'b0}}})
                else $error("upper-immediate gave %h", result);
            // R5
            shl_low_zero_chk: assert (op_sel != 4'd8 || (result & low_mask) == '0)
                else $error("left shift left low bits set: %h", result);
        end
    end
endmodule

bind int_alu int_alu_checker #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
) chk_i (
    .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
    .use_imm(use_imm), .op_sel(op_sel), .result(result), .ovf(ovf)
);

// File: tb/int_alu_tb_top.sv
// Directed bench for the integer execution unit: one task per scenario,
// each applying vectors and checking result and overflow against literals.
module int_alu_tb_top;
    import int_alu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int IMM_W      = 16;
    localparam int SHAMT_W    = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DATA_W-1:0]  src_a = '0;
    logic [DATA_W-1:0]  src_b = '0;
    logic [IMM_W-1:0]   imm = '0;
    logic [SHAMT_W-1:0] shamt = '0;
    logic               use_imm = 1'b0;
    logic [3:0]         op_sel = 4'd0;
    logic [DATA_W-1:0]  result;
    logic               ovf;

    int total_cnt = 0;
    int fail_cnt  = 0;
    bit done      = 1'b0;

    int_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) dut_i (
        .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
        .use_imm(use_imm), .op_sel(op_sel), .result(result), .ovf(ovf)
    );

    // Free-running bench clock.
    always #(CLK_PERIOD/2) clk = ~clk;

    // Apply one vector at a falling edge, sample after the next rising edge.
    task automatic apply_chk(input string tag, input logic [3:0] op,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] im, input logic [4:0] sh,
                             input logic ui, input logic [31:0] exp_res,
                             input logic exp_ovf);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; imm = im; shamt = sh; use_imm = ui;
        @(posedge clk);
        #1;
        total_cnt++;
        if (result !== exp_res || ovf !== exp_ovf) begin
            fail_cnt++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                     tag, result, ovf, exp_res, exp_ovf);
        end
    endtask

    // Idle state after reset with all-zero inputs.
    task automatic test_reset();
        apply_chk("R1 reset idle", OP_ADD, 0, 0, 0, 0, 0, 32'h0, 1'b0);
    endtask

    // R1: additions, immediate sign-extended.
    task automatic test_add();
        apply_chk("R1 add imm", OP_ADD, 32'h4, 32'h55, 16'hFFFF, 0, 1, 32'h3, 0);
        apply_chk("R1 silent add wrap", OP_ADDS, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 32'h0, 0);
        apply_chk("R1 add regs", OP_ADD, 32'h10, 32'h22, 16'h7, 0, 0, 32'h32, 0);
    endtask

    // R2: subtractions.
    task automatic test_sub();
        apply_chk("R2 sub regs", OP_SUB, 32'h4, 32'h1, 0, 0, 0, 32'h3, 0);
        apply_chk("R2 sub imm", OP_SUBS, 32'h4, 0, 16'hFFFF, 0, 1, 32'h5, 0);
    endtask

    // R3: overflow on trapping forms only.
    task automatic test_ovf();
        apply_chk("R3 add ovf", OP_ADD, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 32'h80000000, 1);
        apply_chk("R3 silent add no ovf", OP_ADDS, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 32'h80000000, 0);
        apply_chk("R3 sub ovf", OP_SUB, 32'h80000000, 32'h1, 0, 0, 0, 32'h7FFFFFFF, 1);
        apply_chk("R3 silent sub no ovf", OP_SUBS, 32'h80000000, 32'h1, 0, 0, 0, 32'h7FFFFFFF, 0);
        apply_chk("R3 sub ovf neg min", OP_SUB, 32'h0, 32'h80000000, 0, 0, 0, 32'h80000000, 1);
        apply_chk("R3 add neg no ovf", OP_ADD, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 32'hFFFFFFFE, 0);
    endtask

    // R4: bitwise operations, immediate zero-extended.
    task automatic test_logic();
        apply_chk("R4 and imm", OP_AND, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 0, 1, 32'h0000FFFF, 0);
        apply_chk("R4 or imm", OP_OR, 32'h0, 32'h0, 16'h8000, 0, 1, 32'h00008000, 0);
        apply_chk("R4 xor regs", OP_XOR, 32'hF0F0F0F0, 32'hFF00FF00, 0, 0, 0, 32'h0FF00FF0, 0);
        apply_chk("R4 nor regs", OP_NOR, 32'h00FF0000, 32'h0000000F, 0, 0, 0, 32'hFF00FFF0, 0);
    endtask

    // R5: shifts of src_a by shamt; second operand ignored.
    task automatic test_shift();
        apply_chk("R5 shl", OP_SHL, 32'h1, 32'hFFFF, 0, 5'd5, 0, 32'h20, 0);
        apply_chk("R5 shrl", OP_SHRL, 32'h80000000, 0, 0, 5'd31, 0, 32'h1, 0);
        apply_chk("R5 shra", OP_SHRA, 32'h80000000, 0, 0, 5'd4, 0, 32'hF8000000, 0);
        apply_chk("R5 shra ignores imm", OP_SHRA, 32'h80000000, 32'h1234, 16'h1234, 5'd4, 1,
                  32'hF8000000, 0);
    endtask

    // R6: signed less-than.
    task automatic test_lts();
        apply_chk("R6 1<4", OP_LTS, 32'h1, 32'h4, 0, 0, 0, 32'h1, 0);
        apply_chk("R6 -1<1", OP_LTS, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 32'h1, 0);
        apply_chk("R6 4<1 false", OP_LTS, 32'h4, 32'h1, 0, 0, 0, 32'h0, 0);
        apply_chk("R6 equal false", OP_LTS, 32'h9, 32'h9, 0, 0, 0, 32'h0, 0);
        apply_chk("R6 min<1 across ovf", OP_LTS, 32'h80000000, 32'h1, 0, 0, 0, 32'h1, 0);
        apply_chk("R6 0<imm -1 false", OP_LTS, 32'h0, 0, 16'hFFFF, 0, 1, 32'h0, 0);
    endtask

    // R7: unsigned less-than with sign-extended immediate.
    task automatic test_ltu();
        apply_chk("R7 max<1 false", OP_LTU, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 32'h0, 0);
        apply_chk("R7 1<max", OP_LTU, 32'h1, 32'hFFFFFFFF, 0, 0, 0, 32'h1, 0);
        apply_chk("R7 5<imm FFFF", OP_LTU, 32'h5, 0, 16'hFFFF, 0, 1, 32'h1, 0);
    endtask

    // R8: upper immediate, register operands ignored.
    task automatic test_upi();
        apply_chk("R8 upper imm", OP_UPI, 32'hDEADBEEF, 32'hCAFEF00D, 16'h1234, 5'd3, 0,
                  32'h12340000, 0);
    endtask

    // R9: codes 14 and 15 give zero.
    task automatic test_unused();
        apply_chk("R9 code 14", 4'd14, 32'h7FFFFFFF, 32'h1, 16'hABCD, 5'd2, 0, 32'h0, 0);
        apply_chk("R9 code 15", 4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd1, 1, 32'h0, 0);
    endtask

    // Scenario sequence.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        test_reset();
        test_add();
        test_sub();
        test_ovf();
        test_logic();
        test_shift();
        test_lts();
        test_ltu();
        test_upi();
        test_unused();
        done = 1'b1;
        $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total_cnt++;
            fail_cnt++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
            $finish;
        end
    end
endmodule